// File: doc/BRIEF.md
# UART Receive Interrupt Cause and End-of-Data Detector

This block sits on the receive side of a 16550-style serial port, beside the receive FIFO. It watches the FIFO fill level, the line-error flags of the character at the FIFO head, and how long the serial input has been quiet. From these it forms the interrupt identification value and the interrupt line. The serial deserializer and the FIFO storage are outside the block. The block receives a one-cycle pulse for each character written into the FIFO and a pulse for each bit period.

Besides the usual data-available, line-error, transmit and modem causes, it provides two idle-gap causes. The first is a character timeout. It flags bytes left in the FIFO that a DMA engine moving 4-byte words cannot drain. The second is an end-of-received-data event, raised once the line has been quiet for four character times after data arrived. When an idle gap leaves a residue that is not a multiple of four, both causes are pending and the timeout is reported first. A DMA-driven receiver can then drain the residue by programmed reads and only afterwards learn that the stream has paused. The block also selects which line error to report and requests a receive FIFO flush on a data-less break.

Top module: `rx_eod_irq`

## Requirements
- R1: After reset, `iir` reads 8'h01, `irq` is low and no idle-gap cause is pending.
- R2: `iir` bit 0 is 1 when nothing is pending. Otherwise bits [3:1] carry the cause code: line error 3, receive data 2, timeout 6, end of data 4, transmit 1, modem status 0. The other bits are 0, and `irq` is high exactly when a cause is reported.
- R3: Causes are ranked line error, then receive data, then timeout, then end of data, then transmit, then modem status. Only the highest-ranked active cause is reported.
- R4: The receive data cause (enable `ier[0]`) is active while `rx_level` is at least the trigger level. The trigger level is chosen by `fcr[7:6]`: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 14.
- R5: A character time is one start bit plus 5 + `lcr[1:0]` data bits, plus 2 stop bits when `lcr[2]` is set (else 1), plus one parity bit when `lcr[3]` is set. It is counted in `bit_tick` pulses from the last `rx_stb`.
- R6: End of data (enable `ier[5]`) becomes pending on the `bit_tick` that completes 4 idle character times after an `rx_stb`. It is raised only if a character arrived since the previous end-of-data event.
- R7: Timeout (enable `ier[4]`) becomes pending at that same idle point when `rx_level` mod 4 is non-zero. It clears when `rx_level` is 0 or a character arrives.
- R8: With a non-aligned residue, the timeout is reported first. An IIR read then leaves both causes pending, and end of data is reported once the FIFO is empty.
- R9: End of data clears on an `iir_rd` pulse while it is the reported cause, or when a character arrives.
- R10: `err_sel` is one-hot and follows the precedence overrun, parity, framing, break. The bits of `lsr_err` and `err_sel` are [0] overrun, [1] parity, [2] framing, [3] break. The line cause (enable `ier[2]`) is active when any flag is set.
- R11: `rx_flush` is high when break is the selected error, `rx_level` is 0 and `fifo_err` is set.
- R12: The idle count saturates. A gap of any length raises at most one end-of-data event, and disabled causes never reach `iir`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_stb | input | 1 | One-cycle pulse per received character |
| bit_tick | input | 1 | One pulse per serial bit period |
| lsr_err | input | 4 | Head-character errors: [0] overrun, [1] parity, [2] framing, [3] break |
| fifo_err | input | 1 | An error exists somewhere in the FIFO |
| ier | input | 8 | Interrupt enables: [0] data, [1] tx, [2] line, [3] modem, [4] timeout, [5] end of data |
| fcr | input | 8 | FIFO control; [7:6] receive trigger select |
| lcr | input | 8 | Line control; [1:0] word length, [2] two stop bits, [3] parity enable |
| tx_req | input | 1 | Transmit cause request |
| modem_req | input | 1 | Modem-status cause request |
| iir_rd | input | 1 | Pulse marking a read of the identification value |
| iir | output | 8 | Interrupt identification value |
| irq | output | 1 | Interrupt request |
| err_sel | output | 4 | One-hot selected line error |
| rx_flush | output | 1 | Request to flush the receive FIFO |

## Verification
Several properties are checked on every cycle. An arriving character clears both idle-gap causes. The timeout never outlives an empty FIFO. An end-of-data event is raised only if a character was received since the previous one. The selected error is one-hot and a flush implies a data-less break. An enabled line error always owns the identification value. The exact idle point in bit periods for each word format, and the staged reporting of timeout then end of data, are shown only by the bench's sequences. The same holds for clear-on-read and for saturation over long gaps.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;

  localparam int NUM_CAUSES = 6;

  localparam logic [2:0] CODE_MODEM = 3'd0;
  localparam logic [2:0] CODE_TX    = 3'd1;
  localparam logic [2:0] CODE_DATA  = 3'd2;
  localparam logic [2:0] CODE_LINE  = 3'd3;
  localparam logic [2:0] CODE_EOD   = 3'd4;
  localparam logic [2:0] CODE_TMO   = 3'd6;

  // Bits on the wire for one character, from the line-control value
  function automatic logic [3:0] char_bits(input logic [7:0] lc);
    logic [3:0] n;
    n = 4'd1 + 4'd5 + {2'b00, lc[1:0]};
    n = n + (lc[2] ? 4'd2 : 4'd1);
    n = n + {3'b000, lc[3]};
    return n;
  endfunction

  // Receive trigger level from the two-bit select
  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  // Lowest set bit wins: overrun > parity > framing > break
  function automatic logic [3:0] err_pick(input logic [3:0] e);
    return e & (~e + 4'd1);
  endfunction

  // Cause code for each rank, rank 0 highest
  function automatic logic [2:0] cause_of(input int rank);
    case (rank)
      0:       return CODE_LINE;
      1:       return CODE_DATA;
      2:       return CODE_TMO;
      3:       return CODE_EOD;
      4:       return CODE_TX;
      default: return CODE_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int IDLE_CHARS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_stb,
  input  logic       bit_tick,
  input  logic [3:0] nbits,
  output logic       idle_hit
);
  localparam int CW = $clog2(IDLE_CHARS + 1);
  localparam logic [CW-1:0] LAST_CHR = CW'(IDLE_CHARS - 1);
  localparam logic [CW-1:0] SAT_CHR  = CW'(IDLE_CHARS);

  logic [3:0]    bit_cnt;
  logic [CW-1:0] chr_cnt;
  logic          char_done;

  assign char_done = bit_tick && (bit_cnt >= nbits - 4'd1);
  assign idle_hit  = char_done && (chr_cnt == LAST_CHR) && !rx_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      chr_cnt <= '0;
    end else if (rx_stb) begin
      bit_cnt <= '0;
      chr_cnt <= '0;
    end else if (char_done) begin
      bit_cnt <= '0;
      if (chr_cnt != SAT_CHR) chr_cnt <= chr_cnt + 1'b1;
    end else if (bit_tick) begin
      bit_cnt <= bit_cnt + 4'd1;
    end
  end
endmodule

// File: rtl/rx_err_decode.sv
module rx_err_decode #(
  parameter int LVL_W = 6
) (
  input  logic [LVL_W-1:0] rx_level,
  input  logic [3:0]       lsr_err,
  input  logic             fifo_err,
  output logic [3:0]       err_sel,
  output logic             line_any,
  output logic             rx_flush
);
  import rx_irq_pkg::*;

  assign err_sel  = err_pick(lsr_err);
  assign line_any = |lsr_err;
  assign rx_flush = err_sel[3] && (rx_level == '0) && fifo_err;
endmodule

// File: rtl/rx_irq_prio.sv
module rx_irq_prio (
  input  logic [rx_irq_pkg::NUM_CAUSES-1:0] req,
  output logic [7:0]                        iir,
  output logic                              irq
);
  import rx_irq_pkg::*;

  always_comb begin
    iir = 8'h01;
    for (int r = NUM_CAUSES - 1; r >= 0; r--) begin
      if (req[r]) iir = {4'b0000, cause_of(r), 1'b0};
    end
  end

  assign irq = |req;
endmodule

// File: rtl/rx_eod_irq.sv
module rx_eod_irq #(
  parameter int LVL_W       = 6,
  parameter int IDLE_CHARS  = 4,
  parameter int ALIGN_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_stb,
  input  logic             bit_tick,
  input  logic [3:0]       lsr_err,
  input  logic             fifo_err,
  input  logic [7:0]       ier,
  input  logic [7:0]       fcr,
  input  logic [7:0]       lcr,
  input  logic             tx_req,
  input  logic             modem_req,
  input  logic             iir_rd,
  output logic [7:0]       iir,
  output logic             irq,
  output logic [3:0]       err_sel,
  output logic             rx_flush
);
  import rx_irq_pkg::*;

  localparam int AW = (ALIGN_BYTES > 1) ? $clog2(ALIGN_BYTES) : 1;

  logic [3:0]            nbits;
  logic                  idle_hit;
  logic                  line_any;
  logic                  armed;
  logic                  eod_pend;
  logic                  to_pend;
  logic                  residue;
  logic                  eod_rd_clr;
  logic [LVL_W-1:0]      trig;
  logic [NUM_CAUSES-1:0] req;
  logic                  unused_bits;

  assign unused_bits = ^{fcr[5:0], lcr[7:4], ier[7:6]};

  assign nbits   = char_bits(lcr);
  assign trig    = LVL_W'(trig_level(fcr[7:6]));
  assign residue = (rx_level[AW-1:0] != '0);

  rx_idle_timer #(.IDLE_CHARS(IDLE_CHARS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_stb   (rx_stb),
    .bit_tick (bit_tick),
    .nbits    (nbits),
    .idle_hit (idle_hit)
  );

  rx_err_decode #(.LVL_W(LVL_W)) u_err (
    .rx_level (rx_level),
    .lsr_err  (lsr_err),
    .fifo_err (fifo_err),
    .err_sel  (err_sel),
    .line_any (line_any),
    .rx_flush (rx_flush)
  );

  assign eod_rd_clr = iir_rd && !iir[0] && (iir[3:1] == CODE_EOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      eod_pend <= 1'b0;
      to_pend  <= 1'b0;
    end else if (rx_stb) begin
      armed    <= 1'b1;
      eod_pend <= 1'b0;
      to_pend  <= 1'b0;
    end else begin
      if (idle_hit) begin
        armed    <= 1'b0;
        eod_pend <= armed;
        to_pend  <= residue;
      end
      if (eod_rd_clr) eod_pend <= 1'b0;
      if (rx_level == '0) to_pend <= 1'b0;
    end
  end

  // rank 0 highest
  assign req[0] = ier[2] && line_any;
  assign req[1] = ier[0] && (rx_level >= trig);
  assign req[2] = ier[4] && to_pend;
  assign req[3] = ier[5] && eod_pend;
  assign req[4] = ier[1] && tx_req;
  assign req[5] = ier[3] && modem_req;

  rx_irq_prio u_prio (
    .req (req),
    .iir (iir),
    .irq (irq)
  );
endmodule

// File: rtl/rx_eod_irq_chk.sv
module rx_eod_irq_chk #(
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_stb,
  input logic [LVL_W-1:0] rx_level,
  input logic [3:0]       lsr_err,
  input logic [7:0]       ier,
  input logic [7:0]       iir,
  input logic             irq,
  input logic [3:0]       err_sel,
  input logic             rx_flush,
  input logic             eod_pend,
  input logic             to_pend,
  input logic             armed,
  input logic             idle_hit
);
  // R2
  irq_matches_iir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq != iir[0]);

  // R3
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[2] && (lsr_err != 4'b0)) |-> (iir[3:0] == 4'b0110));

  // R9
  char_clears_eod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |=> (!eod_pend && !to_pend));

  // R7
  empty_clears_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |=> !to_pend);

  // R6
  eod_needs_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eod_pend) |-> $past(armed));

  // R12
  one_eod_per_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |=> !armed);

  // R10
  err_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_sel));

  // R11
  flush_break_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |-> (err_sel == 4'b1000 && rx_level == '0));
endmodule

bind rx_eod_irq rx_eod_irq_chk #(.LVL_W(LVL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_stb   (rx_stb),
  .rx_level (rx_level),
  .lsr_err  (lsr_err),
  .ier      (ier),
  .iir      (iir),
  .irq      (irq),
  .err_sel  (err_sel),
  .rx_flush (rx_flush),
  .eod_pend (eod_pend),
  .to_pend  (to_pend),
  .armed    (armed),
  .idle_hit (idle_hit)
);

// File: tb/rx_eod_irq_test.sv
module rx_eod_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] rx_level = '0;
  logic       rx_stb = 1'b0;
  logic       bit_tick = 1'b0;
  logic [3:0] lsr_err = '0;
  logic       fifo_err = 1'b0;
  logic [7:0] ier = '0;
  logic [7:0] fcr = '0;
  logic [7:0] lcr = 8'h03;
  logic       tx_req = 1'b0;
  logic       modem_req = 1'b0;
  logic       iir_rd = 1'b0;
  logic [7:0] iir;
  logic       irq;
  logic [3:0] err_sel;
  logic       rx_flush;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rx_eod_irq uut (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_stb(rx_stb),
    .bit_tick(bit_tick), .lsr_err(lsr_err), .fifo_err(fifo_err),
    .ier(ier), .fcr(fcr), .lcr(lcr), .tx_req(tx_req),
    .modem_req(modem_req), .iir_rd(iir_rd), .iir(iir), .irq(irq),
    .err_sel(err_sel), .rx_flush(rx_flush)
  );

  // {lsr_err, level, ier, fcr, tx, modem, exp_iir, exp_err}
  localparam int NV = 16;
  localparam logic [39:0] VEC [NV] = '{
    {4'b0000, 6'd0,  8'h00, 8'h00, 1'b0, 1'b0, 8'h01, 4'b0000},
    {4'b0000, 6'd0,  8'h08, 8'h00, 1'b0, 1'b1, 8'h00, 4'b0000},
    {4'b0000, 6'd0,  8'h02, 8'h00, 1'b1, 1'b0, 8'h02, 4'b0000},
    {4'b0000, 6'd0,  8'h0A, 8'h00, 1'b1, 1'b1, 8'h02, 4'b0000},
    {4'b0000, 6'd4,  8'h01, 8'h40, 1'b0, 1'b0, 8'h04, 4'b0000},
    {4'b0000, 6'd3,  8'h01, 8'h40, 1'b0, 1'b0, 8'h01, 4'b0000},
    {4'b0000, 6'd1,  8'h01, 8'h00, 1'b0, 1'b0, 8'h04, 4'b0000},
    {4'b0000, 6'd13, 8'h01, 8'hC0, 1'b0, 1'b0, 8'h01, 4'b0000},
    {4'b0000, 6'd14, 8'h01, 8'hC0, 1'b0, 1'b0, 8'h04, 4'b0000},
    {4'b0000, 6'd7,  8'h01, 8'h80, 1'b0, 1'b0, 8'h01, 4'b0000},
    {4'b0000, 6'd8,  8'h03, 8'h80, 1'b1, 1'b0, 8'h04, 4'b0000},
    {4'b0010, 6'd8,  8'h07, 8'h80, 1'b1, 1'b0, 8'h06, 4'b0010},
    {4'b0010, 6'd8,  8'h03, 8'h80, 1'b0, 1'b0, 8'h04, 4'b0010},
    {4'b1111, 6'd0,  8'h04, 8'h00, 1'b0, 1'b0, 8'h06, 4'b0001},
    {4'b1100, 6'd0,  8'h04, 8'h00, 1'b0, 1'b0, 8'h06, 4'b0100},
    {4'b0000, 6'd4,  8'h00, 8'h40, 1'b0, 1'b0, 8'h01, 4'b0000}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    bit_tick = 1'b1;
    repeat (n) @(negedge clk);
    bit_tick = 1'b0;
    #1;
  endtask

  task automatic stb();
    rx_stb = 1'b1;
    @(negedge clk);
    rx_stb = 1'b0;
    #1;
  endtask

  task automatic rd();
    iir_rd = 1'b1;
    @(negedge clk);
    iir_rd = 1'b0;
    #1;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 iir", iir, 8'h01);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 flush", {7'b0, rx_flush}, 8'h00);

    // R2 R3 R4 R10 table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {lsr_err, rx_level, ier, fcr, tx_req, modem_req} = VEC[i][39:12];
      #1;
      chk("R2/R3/R4 iir", iir, VEC[i][11:4]);
      chk("R10 err_sel", {4'b0, err_sel}, {4'b0, VEC[i][3:0]});
      chk("R2 irq", {7'b0, irq}, {7'b0, ~VEC[i][4]});
    end
    @(negedge clk);
    lsr_err = '0; tx_req = 0; modem_req = 0; fcr = 8'h00;
    ier = 8'h30; rx_level = 6'd0; lcr = 8'h03;
    #1;

    // R6 no character since reset: gap raises nothing
    ticks(40);
    chk("R6 unarmed", iir, 8'h01);

    // R8 residue 3: timeout first, then end of data
    rx_level = 6'd3;
    stb();
    ticks(39);
    chk("R6 before idle point", iir, 8'h01);
    ticks(1);
    chk("R8 timeout first", iir, 8'h0C);
    chk("R8 irq", {7'b0, irq}, 8'h01);
    rd();
    chk("R8 read keeps timeout", iir, 8'h0C);
    rx_level = 6'd0;
    @(negedge clk); #1;
    chk("R8 eod after drain", iir, 8'h08);
    rd();
    chk("R9 read clears eod", iir, 8'h01);
    ticks(60);
    chk("R12 saturated gap", iir, 8'h01);

    // R7 aligned level: end of data only
    rx_level = 6'd4;
    stb();
    ticks(40);
    chk("R7 aligned no timeout", iir, 8'h08);
    stb();
    chk("R9 char clears eod", iir, 8'h01);

    // R5 12-bit character
    lcr = 8'h0F;
    stb();
    ticks(47);
    chk("R5 12-bit before", iir, 8'h01);
    ticks(1);
    chk("R5 12-bit at idle", iir, 8'h08);

    // R5 7-bit character
    lcr = 8'h00;
    stb();
    ticks(27);
    chk("R5 7-bit before", iir, 8'h01);
    ticks(1);
    chk("R5 7-bit at idle", iir, 8'h08);

    // R7 timeout clears when empty; R12 eod masked
    lcr = 8'h03; ier = 8'h10; rx_level = 6'd2;
    stb();
    ticks(40);
    chk("R7 timeout alone", iir, 8'h0C);
    rx_level = 6'd0;
    @(negedge clk); #1;
    chk("R7/R12 empty clears, eod masked", iir, 8'h01);

    // R3 data above timeout
    ier = 8'h31; fcr = 8'h00; rx_level = 6'd2;
    stb();
    ticks(40);
    chk("R3 data over timeout", iir, 8'h04);
    stb();

    // R11 flush
    ier = 8'h00; rx_level = 6'd0; lsr_err = 4'b1000; fifo_err = 1'b1;
    #1;
    chk("R11 flush on break", {7'b0, rx_flush}, 8'h01);
    fifo_err = 1'b0; #1;
    chk("R11 no fifo error", {7'b0, rx_flush}, 8'h00);
    fifo_err = 1'b1; rx_level = 6'd1; #1;
    chk("R11 data present", {7'b0, rx_flush}, 8'h00);
    rx_level = 6'd0; lsr_err = 4'b1001; #1;
    chk("R11 overrun wins", {7'b0, rx_flush}, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule